// File: doc/BRIEF.md
# Dual Comparator Output Router

This block takes the already-computed digital results of two comparator channels and turns them into data outputs, a shared interrupt request and per-channel pin-route enables. Each channel's result is resynchronized, then drives a set/reset latch. A per-channel select chooses whether downstream logic sees the raw result or the latched value. The chosen value feeds the capacitive-sense path and the interrupt path.

Software sets up the block through an 8-bit control register. A second register shows the live latch states, and writing to it can clear them. Each latch can be cleared in one of two ways, chosen per channel: by software, or by a rising edge on the other channel's result. In the second mode the two channels form a cross-coupled set/reset pair without software involvement.

Top module: `cmp_out_router`

## Requirements
- R1: Control register (`reg_sel`=0) bit map: bit 0 data select ch0, bit 1 clear source ch0, bit 2 pin select ch0, bit 3 interrupt enable ch0, bit 4 data select ch1, bit 5 clear source ch1, bit 6 pin select ch1, bit 7 interrupt enable ch1. All bits are writable and read back unchanged.
- R2: After reset, the control register and both latches are 0, and `irq`, `data_out` and `pin_en` are 0.
- R3: With data select 0, `data_out[i]` is the synchronized result of channel i. With data select 1, it is latch i.
- R4: Latch i is set on a rising edge of the synchronized result of channel i. The latch register (`reg_sel`=1) reads latch 0 on bit 0 and latch 1 on bit 1, with the upper bits 0.
- R5: With clear source 0, writing 0 to bit i of the latch register clears latch i. Writing 1 leaves it unchanged.
- R6: With clear source 1, latch i clears on a rising edge of the other channel's synchronized result, and software writes to the latch register leave it unchanged.
- R7: A rising edge on an enabled channel's `data_out` raises `irq` on the next clock. In result mode, that is three clocks after `lut_in` changes. In latch mode, it is four clocks after the change.
- R8: `irq` needs `int_mask_en`=1. A rising edge on either enabled channel raises it, and a disabled channel never does.
- R9: `pin_en[i]` is 1 exactly when pin select i and `out_cfg_en[i]` are both 1.
- R10: When a set and a clear reach a latch in the same cycle, the clear wins.
- R11: `irq` is a single-cycle pulse for each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lut_in | input | 2 | Asynchronous comparator results, bit i for channel i |
| reg_sel | input | 1 | Register select: 0 control, 1 latch |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| int_mask_en | input | 1 | External interrupt mask enable |
| out_cfg_en | input | 2 | External per-channel output-config enable |
| data_out | output | 2 | Selected data output per channel |
| irq | output | 1 | Shared interrupt request pulse |
| pin_en | output | 2 | Per-channel pin-route enable |

## Verification
The hardest situation to reach is both latches receiving a set and a cross-coupled clear on the same clock edge. The stimulus first puts both channels in edge-clear mode, then drives both inputs low and waits for the synchronizers to settle. It then raises both inputs on the same edge, so both synchronized results rise in the same cycle. Latch-mode interrupt timing is reached by a similar path: the latches are emptied first, and then a single rising edge is timed through the synchronizer, the latch and the edge detector.

// File: rtl/cmp_out_router.sv
module cmp_out_router #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lut_in,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       int_mask_en,
  input  logic [1:0] out_cfg_en,
  output logic [1:0] data_out,
  output logic       irq,
  output logic [1:0] pin_en
);

  logic [7:0] ctrl_q;
  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] lut, lut_prev, latch_q, dout_prev;
  logic [1:0] int_en, pin_sel, clr_src, dsel;
  logic [1:0] rise_lut, rise_other, sw_clr, clr, rise_dout;

  assign dsel    = {ctrl_q[4], ctrl_q[0]};
  assign clr_src = {ctrl_q[5], ctrl_q[1]};
  assign pin_sel = {ctrl_q[6], ctrl_q[2]};
  assign int_en  = {ctrl_q[7], ctrl_q[3]};

  assign lut        = sync_q[SYNC_STAGES-1];
  assign rise_lut   = lut & ~lut_prev;
  assign rise_other = {rise_lut[0], rise_lut[1]};
  assign sw_clr     = {2{wr_en & reg_sel}} & ~wr_data[1:0];
  assign clr        = (clr_src & rise_other) | (~clr_src & sw_clr);

  assign data_out  = (dsel & latch_q) | (~dsel & lut);
  assign rise_dout = data_out & ~dout_prev;
  assign pin_en    = pin_sel & out_cfg_en;
  assign rd_data   = reg_sel ? {6'b0, latch_q} : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      ctrl_q    <= '0;
      lut_prev  <= '0;
      latch_q   <= '0;
      dout_prev <= '0;
      irq       <= 1'b0;
    end else begin
      sync_q[0] <= lut_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      if (wr_en && !reg_sel) ctrl_q <= wr_data;
      lut_prev  <= lut;
      latch_q   <= (latch_q | rise_lut) & ~clr;
      dout_prev <= data_out;
      irq       <= int_mask_en & |(rise_dout & int_en);
    end
  end

  a_r4_set_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_lut[0] && !rise_lut[1] && !(wr_en && reg_sel)) |=> latch_q[0]);
  a_r6_cross_clear_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_src[0] && rise_lut[1]) |=> !latch_q[0]);
  a_r6_cross_clear_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_src[1] && rise_lut[0]) |=> !latch_q[1]);
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(int_mask_en));
  a_r7_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(int_en) != 2'b00));

endmodule

// File: tb/cmp_out_router_tb.sv
module cmp_out_router_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] lut_in = 0, out_cfg_en = 0, data_out, pin_en;
  logic reg_sel = 0, wr_en = 0, int_mask_en = 0, irq;
  logic [7:0] wr_data = 0, rd_data;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cmp_out_router u_dut (.clk, .rst_n, .lut_in, .reg_sel, .wr_en, .wr_data, .rd_data,
    .int_mask_en, .out_cfg_en, .data_out, .irq, .pin_en);

  // {ctrl, lut, mask, cfg, exp_dout, exp_irq, exp_pin}
  localparam logic [17:0] VEC [11] = '{
    {8'h00, 2'b01, 1'b1, 2'b00, 2'b01, 1'b0, 2'b00},
    {8'h08, 2'b00, 1'b1, 2'b00, 2'b00, 1'b0, 2'b00},
    {8'h08, 2'b01, 1'b1, 2'b00, 2'b01, 1'b1, 2'b00},
    {8'h08, 2'b11, 1'b1, 2'b00, 2'b11, 1'b0, 2'b00},
    {8'h88, 2'b00, 1'b1, 2'b00, 2'b00, 1'b0, 2'b00},
    {8'h88, 2'b10, 1'b0, 2'b00, 2'b10, 1'b0, 2'b00},
    {8'h88, 2'b11, 1'b1, 2'b00, 2'b11, 1'b1, 2'b00},
    {8'h44, 2'b11, 1'b1, 2'b01, 2'b11, 1'b0, 2'b01},
    {8'h44, 2'b11, 1'b1, 2'b11, 2'b11, 1'b0, 2'b11},
    {8'h44, 2'b11, 1'b1, 2'b10, 2'b11, 1'b0, 2'b10},
    {8'h11, 2'b00, 1'b1, 2'b00, 2'b11, 1'b0, 2'b00}
  };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic sel, logic [7:0] exp);
    reg_sel = sel; #0.1; chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    out_cfg_en = 2'b11;
    tick(2); rst_n = 1; tick();
    rd_chk("R2 ctrl", 0, 8'h00);
    rd_chk("R2 latch", 1, 8'h00);
    chk("R2 irq", {7'b0, irq}, 0);
    chk("R2 dout", {6'b0, data_out}, 0);
    chk("R2 pin", {6'b0, pin_en}, 0);

    for (int v = 0; v < 11; v++) begin
      lut_in = VEC[v][9:8]; int_mask_en = VEC[v][7]; out_cfg_en = VEC[v][6:5];
      wr(0, VEC[v][17:10]);
      tick(2);
      chk("R3/R9 dout", {6'b0, data_out}, {6'b0, VEC[v][4:3]});
      chk("R7/R8 irq", {7'b0, irq}, {7'b0, VEC[v][2]});
      chk("R9 pin", {6'b0, pin_en}, {6'b0, VEC[v][1:0]});
      tick();
      chk("R11 irq pulse", {7'b0, irq}, 0);
      tick();
    end

    rd_chk("R1 ctrl readback", 0, 8'h11);
    wr(1, 8'h02);
    rd_chk("R5 sw clear", 1, 8'h02);
    chk("R3 latch mode dout", {6'b0, data_out}, 8'h02);
    wr(0, 8'h33);
    wr(1, 8'h00);
    rd_chk("R6 sw write ignored", 1, 8'h02);
    lut_in = 2'b01; tick(3);
    rd_chk("R4/R6 set ch0 clear ch1", 1, 8'h01);
    lut_in = 2'b11; tick(3);
    rd_chk("R4/R6 set ch1 clear ch0", 1, 8'h02);
    lut_in = 2'b00; tick(3);
    lut_in = 2'b11; tick(3);
    rd_chk("R10 clear wins", 1, 8'h00);
    lut_in = 2'b00; tick(3);
    wr(0, 8'h19);
    lut_in = 2'b01; tick(3);
    chk("R7 latch mode not yet", {7'b0, irq}, 0);
    tick();
    chk("R7 latch mode irq", {7'b0, irq}, 1);
    tick();
    chk("R11 latch irq pulse", {7'b0, irq}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule